// File: doc/BRIEF.md
# Interrupt Ring Reader with Overflow Recovery

This block drains a circular buffer of interrupt vectors that a producer elsewhere on the chip fills. The buffer lives in a memory with one synchronous read port. When the block is kicked, it samples the producer's write pointer. It then walks its own read pointer forward one 16-byte vector at a time, fetching four dwords per vector, and hands each decoded vector to a downstream sink over a valid/ready stream. Once the read pointer catches up with the write pointer, the block publishes the final read pointer on one of two write paths: a doorbell write or a register write. Which path it uses is set by a configuration input.

If the sampled write pointer carries the overflow flag, the producer has lapped the reader. In that case the block throws away its stale position and restarts just past the write pointer, at the oldest vector that has not been overwritten. It also raises a single-cycle request asking the producer side to clear the flag. After each publish, the block looks at the write pointer one more time. Vectors that arrived during the drain are therefore handled before it goes idle.

Top module: `ih_ring_reader`

## Requirements
- R1: After reset, out_valid, mem_rd_en, db_wr, reg_wr and ovf_clr are all low, and the internal read pointer is 0. A kick with write pointer 0 therefore drains nothing and publishes 0.
- R2: A kick is accepted only while idle. The write pointer is sampled in the following cycle. Bit 0 of wptr_in is the overflow flag and is cleared before use. Bits at or above RING_LOG2 are ignored, so the pointer is masked to the ring size. Write pointers are byte addresses and multiples of 16.
- R3: Each vector is fetched as four reads on consecutive cycles. The reads go to dword indices rptr>>2 through (rptr>>2)+3, and the read data is taken one cycle after each read.
- R4: Decoded fields come from the fetched dwords: source id = dword0[7:0], source data = dword1[27:0], ring id = dword2[7:0], VMID = dword2[15:8], PASID = dword2[31:16].
- R5: A vector on the output holds its value, with out_valid high, until out_ready is seen. No memory read is issued while out_valid is high.
- R6: After each vector, the read pointer advances by 16 modulo the ring size. Vectors come out in ring order until the read pointer equals the masked write pointer.
- R7: When the overflow flag is set, the read pointer is replaced by (write pointer + 16) masked to the ring size before draining starts.
- R8: Each overflow detection produces exactly one single-cycle pulse on ovf_clr.
- R9: When the pointers become equal, the read pointer is published on rptr_pub with a one-cycle pulse. The pulse goes on db_wr when cfg_use_doorbell is 1 and on reg_wr otherwise, never on both.
- R10: After a publish, the write pointer is sampled once more. New vectors are drained and published again. If nothing has arrived, the block returns to idle without a further publish.
- R11: A kick that arrives while the block is busy has no effect: no extra vectors and no extra publish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start a drain pass (sampled when idle) |
| cfg_use_doorbell | input | 1 | 1: publish on doorbell path, 0: register path |
| wptr_in | input | PTR_W | Producer write pointer in bytes, bit 0 = overflow flag |
| mem_rd_en | output | 1 | Ring memory read strobe |
| mem_rd_addr | output | RING_LOG2-2 | Ring memory dword index |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| out_valid | output | 1 | Decoded vector valid |
| out_ready | input | 1 | Sink accepts vector |
| out_src_id | output | 8 | Source id |
| out_src_data | output | 28 | Source data |
| out_ring_id | output | 8 | Ring id |
| out_vmid | output | 8 | VMID |
| out_pasid | output | 16 | PASID |
| db_wr | output | 1 | Doorbell publish pulse |
| reg_wr | output | 1 | Register publish pulse |
| rptr_pub | output | PTR_W | Published read pointer |
| ovf_clr | output | 1 | One-shot overflow-clear request |

## Verification
The bench builds the block with RING_LOG2 = 8 and PTR_W = 32. That gives a 256-byte ring of 16 vector slots. With so few slots, wrap-around past the top of the ring happens within a few batches, and an overflow drain of the whole ring takes only 15 vectors. Because of that, resumption at the very last slot (write pointer 0xF0 giving restart at 0x00) and a second drain triggered by the post-publish resample both fit in short directed runs. Those runs sit alongside random batches with random sink back-pressure.

// File: rtl/ih_ring_pkg.sv
package ih_ring_pkg;

  localparam int VEC_BYTES  = 16;
  localparam int VEC_DWORDS = 4;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } ih_vec_t;

endpackage

// File: rtl/ih_wptr_eval.sv
module ih_wptr_eval
  import ih_ring_pkg::*;
#(
  parameter int RING_LOG2 = 8
) (
  input  logic [RING_LOG2-1:0] raw,
  output logic [RING_LOG2-1:0] wp,
  output logic                 ovf,
  output logic [RING_LOG2-1:0] resume
);

  // flag sits in bit 0; vectors are 16-byte aligned so the bit is free
  assign ovf    = raw[0];
  assign wp     = {raw[RING_LOG2-1:1], 1'b0};
  // first slot not yet overwritten; width truncation applies the ring mask
  assign resume = wp + RING_LOG2'(VEC_BYTES);

endmodule

// File: rtl/ih_vec_fetch.sv
module ih_vec_fetch
  import ih_ring_pkg::*;
#(
  parameter  int RING_LOG2 = 8,
  localparam int AW        = RING_LOG2 - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_idx,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          done,
  output ih_vec_t       vec
);

  localparam int CW = $clog2(VEC_DWORDS);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          cap_vld;
  logic [CW-1:0] cap_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cap_vld <= 1'b0;
      cap_idx <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(VEC_DWORDS - 1)) busy <= 1'b0;
      end
      cap_vld <= busy;
      cap_idx <= cnt;
    end
  end

  // data returns one cycle after each strobe; last dword carries no field
  always_ff @(posedge clk) begin
    if (cap_vld) begin
      case (cap_idx)
        CW'(0): vec.src_id   <= mem_rd_data[7:0];
        CW'(1): vec.src_data <= mem_rd_data[27:0];
        CW'(2): begin
          vec.ring_id <= mem_rd_data[7:0];
          vec.vmid    <= mem_rd_data[15:8];
          vec.pasid   <= mem_rd_data[31:16];
        end
        default: ;
      endcase
    end
  end

  assign mem_rd_en   = busy;
  assign mem_rd_addr = base_idx + AW'(cnt);
  assign done        = cap_vld && (cap_idx == CW'(VEC_DWORDS - 1));

  // R3: the four reads of one vector hit consecutive dword indices
  a_r3_consecutive_reads: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && cnt != CW'(VEC_DWORDS - 1)) |=>
      (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + AW'(1)));

endmodule

// File: rtl/ih_ring_reader.sv
module ih_ring_reader
  import ih_ring_pkg::*;
#(
  parameter  int PTR_W     = 32,
  parameter  int RING_LOG2 = 8,
  localparam int AW        = RING_LOG2 - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             cfg_use_doorbell,
  input  logic [PTR_W-1:0] wptr_in,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [31:0]      mem_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_src_id,
  output logic [27:0]      out_src_data,
  output logic [7:0]       out_ring_id,
  output logic [7:0]       out_vmid,
  output logic [15:0]      out_pasid,
  output logic             db_wr,
  output logic             reg_wr,
  output logic [PTR_W-1:0] rptr_pub,
  output logic             ovf_clr
);

  typedef enum logic [2:0] {S_IDLE, S_SAMPLE, S_CMP, S_FETCH, S_OUT} st_t;

  st_t                  state;
  logic [RING_LOG2-1:0] rptr_q;
  logic [RING_LOG2-1:0] wp_q;
  logic                 pub_done;
  ih_vec_t              out_vec;

  logic [RING_LOG2-1:0] wp_now;
  logic [RING_LOG2-1:0] resume_ptr;
  logic                 ovf_now;
  logic                 fetch_start;
  logic                 fetch_done;
  ih_vec_t              fetch_vec;
  logic                 unused_wp_hi;

  assign unused_wp_hi = ^wptr_in[PTR_W-1:RING_LOG2];

  ih_wptr_eval #(.RING_LOG2(RING_LOG2)) u_eval (
    .raw    (wptr_in[RING_LOG2-1:0]),
    .wp     (wp_now),
    .ovf    (ovf_now),
    .resume (resume_ptr)
  );

  assign fetch_start = (state == S_CMP) && (rptr_q != wp_q);

  ih_vec_fetch #(.RING_LOG2(RING_LOG2)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .start       (fetch_start),
    .base_idx    (rptr_q[RING_LOG2-1:2]),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .done        (fetch_done),
    .vec         (fetch_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rptr_q    <= '0;
      wp_q      <= '0;
      pub_done  <= 1'b0;
      out_valid <= 1'b0;
      out_vec   <= '0;
      db_wr     <= 1'b0;
      reg_wr    <= 1'b0;
      rptr_pub  <= '0;
      ovf_clr   <= 1'b0;
    end else begin
      db_wr   <= 1'b0;
      reg_wr  <= 1'b0;
      ovf_clr <= 1'b0;
      unique case (state)
        S_IDLE: if (kick) begin
          pub_done <= 1'b0;
          state    <= S_SAMPLE;
        end
        S_SAMPLE: begin
          wp_q <= wp_now;
          if (ovf_now) begin
            rptr_q  <= resume_ptr;
            ovf_clr <= 1'b1;
          end
          state <= S_CMP;
        end
        S_CMP: begin
          if (rptr_q == wp_q) begin
            if (!pub_done) begin
              db_wr    <= cfg_use_doorbell;
              reg_wr   <= !cfg_use_doorbell;
              rptr_pub <= PTR_W'(rptr_q);
              pub_done <= 1'b1;
              state    <= S_SAMPLE;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: if (fetch_done) begin
          out_valid <= 1'b1;
          out_vec   <= fetch_vec;
          rptr_q    <= rptr_q + RING_LOG2'(VEC_BYTES);
          pub_done  <= 1'b0;
          state     <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= S_CMP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_src_id   = out_vec.src_id;
  assign out_src_data = out_vec.src_data;
  assign out_ring_id  = out_vec.ring_id;
  assign out_vmid     = out_vec.vmid;
  assign out_pasid    = out_vec.pasid;

  // R5: stalled vector stays put
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  // R5: no fetch while the output holds a vector
  a_r5_no_fetch_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !mem_rd_en);

  // R9: publish goes on exactly one path
  a_r9_one_path: assert property (@(posedge clk) disable iff (rst)
    !(db_wr && reg_wr));

  // R8: overflow-clear request is single-cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |=> !ovf_clr);

  // R10: idle means nothing in flight
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (!out_valid && !mem_rd_en));

endmodule

// File: tb/tb_ih_ring_reader.sv
`timescale 1ns/1ps
module tb_ih_ring_reader;

  localparam int PTR_W     = 32;
  localparam int RING_LOG2 = 8;
  localparam int AW        = RING_LOG2 - 2;
  localparam int RMASK     = (1 << RING_LOG2) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             kick = 1'b0;
  logic             cfg_use_doorbell = 1'b0;
  logic [PTR_W-1:0] wptr_in = '0;
  logic             mem_rd_en;
  logic [AW-1:0]    mem_rd_addr;
  logic [31:0]      mem_rd_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [7:0]       out_src_id;
  logic [27:0]      out_src_data;
  logic [7:0]       out_ring_id;
  logic [7:0]       out_vmid;
  logic [15:0]      out_pasid;
  logic             db_wr;
  logic             reg_wr;
  logic [PTR_W-1:0] rptr_pub;
  logic             ovf_clr;

  always #2.5 clk = ~clk;

  ih_ring_reader #(.PTR_W(PTR_W), .RING_LOG2(RING_LOG2)) dut (
    .clk(clk), .rst(rst), .kick(kick), .cfg_use_doorbell(cfg_use_doorbell),
    .wptr_in(wptr_in), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_src_id(out_src_id), .out_src_data(out_src_data), .out_ring_id(out_ring_id),
    .out_vmid(out_vmid), .out_pasid(out_pasid), .db_wr(db_wr), .reg_wr(reg_wr),
    .rptr_pub(rptr_pub), .ovf_clr(ovf_clr)
  );

  // ring memory model with one synchronous read port
  logic [31:0] ring [0:(1<<AW)-1];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= ring[mem_rd_addr];

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;

  logic [67:0] expq [0:63];
  int          exp_h, exp_t;
  int          pubq [0:3];
  int          pub_h, pub_t;
  int          exp_r = 0;
  int          ovf_cnt;
  bit          rs_arm, bk_arm, kick_next, rdy_rand, prev_stall;
  int          rs_wp;
  logic [67:0] held;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R6 watchdog expired actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4 field layout: {src=d0[7:0], data=d1[27:0], ring=d2[7:0], vmid=d2[15:8], pasid=d2[31:16]}
  function automatic logic [67:0] exp_word(input int p);
    int i = p >> 2;
    return {ring[i][7:0], ring[i+1][27:0], ring[i+2][7:0], ring[i+2][15:8], ring[i+2][31:16]};
  endfunction

  function automatic logic [67:0] dut_word();
    return {out_src_id, out_src_data, out_ring_id, out_vmid, out_pasid};
  endfunction

  task automatic step();
    @(negedge clk);
    kick = kick_next;
    kick_next = 1'b0;
    out_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
    if (prev_stall) chk(out_valid && dut_word() == held, "R5 stalled vector changed", dut_word(), held);
    if (out_valid) chk(!mem_rd_en, "R5 read while output stalled", 68'(mem_rd_en), 68'(0));
    if (out_valid && out_ready) begin
      if (exp_h == exp_t) chk(1'b0, "R6 unexpected vector", dut_word(), 68'(0));
      else begin
        chk(dut_word() == expq[exp_h], "R4 R3 vector contents", dut_word(), expq[exp_h]);
        exp_h++;
      end
      if (bk_arm) begin kick_next = 1'b1; bk_arm = 1'b0; end
    end
    prev_stall = out_valid && !out_ready;
    held = dut_word();
    if (db_wr || reg_wr) begin
      chk(db_wr == cfg_use_doorbell && reg_wr == !cfg_use_doorbell, "R9 publish path",
          68'({db_wr, reg_wr}), 68'({cfg_use_doorbell, !cfg_use_doorbell}));
      if (pub_h == pub_t) chk(1'b0, "R10 R11 unexpected publish", 68'(rptr_pub), 68'(0));
      else begin
        chk(rptr_pub == PTR_W'(pubq[pub_h]), "R9 published pointer", 68'(rptr_pub), 68'(pubq[pub_h]));
        pub_h++;
      end
      if (rs_arm) begin wptr_in = PTR_W'(rs_wp); rs_arm = 1'b0; end
    end
    if (ovf_clr) begin
      ovf_cnt++;
      wptr_in[0] = 1'b0;
    end
  endtask

  task automatic run_batch(input int wp, input bit ovf, input bit db,
                           input bit resample, input int wp2, input bit bkick);
    int r;
    int guard;
    for (int i = 0; i < (1 << AW); i++) ring[i] = $urandom;
    exp_h = 0; exp_t = 0; pub_h = 0; pub_t = 0; ovf_cnt = 0;
    r = ovf ? ((wp + 16) & RMASK) : exp_r;
    while (r != wp) begin expq[exp_t] = exp_word(r); exp_t++; r = (r + 16) & RMASK; end
    pubq[pub_t] = wp; pub_t++;
    if (resample) begin
      while (r != wp2) begin expq[exp_t] = exp_word(r); exp_t++; r = (r + 16) & RMASK; end
      pubq[pub_t] = wp2; pub_t++;
    end
    exp_r = r;
    cfg_use_doorbell = db;
    wptr_in = PTR_W'(wp | int'(ovf));
    rs_arm = resample; rs_wp = wp2; bk_arm = bkick;
    kick_next = 1'b1;
    guard = 0;
    while ((exp_h != exp_t || pub_h != pub_t) && guard < 5000) begin step(); guard++; end
    repeat (16) step();
    chk(exp_h == exp_t, "R6 vector count", 68'(exp_h), 68'(exp_t));
    chk(pub_h == pub_t, "R10 publish count", 68'(pub_h), 68'(pub_t));
    chk(ovf_cnt == int'(ovf), "R8 R7 overflow-clear pulses", 68'(ovf_cnt), 68'(ovf));
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rdy_rand = 1'b0; prev_stall = 1'b0; kick_next = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1 out_valid after reset", 68'(out_valid), 68'(0));
    chk(!mem_rd_en, "R1 mem_rd_en after reset", 68'(mem_rd_en), 68'(0));
    chk(!db_wr && !reg_wr, "R1 publish after reset", 68'({db_wr, reg_wr}), 68'(0));
    chk(!ovf_clr, "R1 ovf_clr after reset", 68'(ovf_clr), 68'(0));

    run_batch(32'h00, 1'b0, 1'b1, 1'b0, 0, 1'b0);   // R1 empty ring publishes 0
    run_batch(32'h30, 1'b0, 1'b0, 1'b0, 0, 1'b0);   // R2 R6 three vectors, register path
    run_batch(32'h20, 1'b0, 1'b1, 1'b0, 0, 1'b0);   // R6 wrap past top of ring
    wptr_in = PTR_W'(32'hFFFF_FF00);                // R2 upper bits ignored while idle
    repeat (4) step();
    rdy_rand = 1'b1;
    run_batch(32'h40, 1'b1, 1'b0, 1'b0, 0, 1'b0);   // R7 overflow restart at 0x50
    run_batch(32'hF0, 1'b1, 1'b1, 1'b0, 0, 1'b0);   // R7 restart wraps to 0x00
    run_batch(32'h20, 1'b0, 1'b1, 1'b1, 32'h50, 1'b0); // R10 resample drains new entries
    run_batch(32'h90, 1'b0, 1'b0, 1'b0, 0, 1'b1);   // R11 kick while busy
    for (int k = 0; k < 24; k++) begin
      int w = int'($urandom % 16) * 16;
      bit o = ($urandom % 5 == 0);
      rdy_rand = ($urandom % 2 == 0);
      run_batch(w, o, $urandom % 2, 1'b0, 0, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule